// File: doc/BRIEF.md
# Exception Acceptance Gating Unit

This unit sits next to the decode stage of a simple in-order processor. It makes one decision for each decoded instruction: whether a pending address error or a pending interrupt may be taken now, or whether it must wait for a later instruction. It also raises illegal-instruction exceptions for undefined opcodes. For every exception it takes, it picks the program counter value to save.

Acceptance depends on the class of the instruction decoded just before. An instruction in the delay slot of a delayed branch accepts nothing. A delayed branch and its slot instruction therefore always run back to back. An instruction that follows a transfer to or from a control or system register refuses interrupts but accepts address errors. An address error that cannot be taken stays latched until some instruction can take it.

The decoder supplies class flags for each instruction. It flags every delayed-branch form (jumps, branches, calls, returns, return from exception and the conditional forms with a slot) and every interrupt-disabling register transfer. It also supplies the decoded PC and, for a delayed branch, its target. Vector fetch, stacking of status and interrupt priority arbitration are handled elsewhere.

Top module: `exc_gate`

## Requirements
- R1: When the decoded instruction sits in a delay slot, meaning the last valid unstalled decode was a delayed branch that took no exception, neither an address error (cause 3) nor an interrupt (cause 4) is taken for it.
- R2: When the decoded instruction directly follows an interrupt-disabling instruction, no interrupt is taken for it, but a pending address error is taken.
- R3: An address error pulse that cannot be accepted is latched. It is taken on the first later decode that allows it, and the latch is cleared only in the cycle it is taken.
- R4: An interrupt counts as pending only when `irq_level` is strictly greater than `irq_mask`. This comparison is made afresh at every decode, so a request that is withdrawn or drops to or below the mask is not taken.
- R5: An undefined opcode decoded outside a delay slot raises cause 1 (general illegal), and the saved PC is the opcode's own `dec_pc`.
- R6: An undefined opcode decoded in a delay slot raises cause 2 (illegal slot), and the saved PC is the `br_target` captured with the preceding delayed branch.
- R7: At most one exception is taken per decode. The order of priority is address error, then illegal instruction, then interrupt. Address errors and interrupts save `dec_pc`.
- R8: `exc_take`, `exc_cause` and `exc_pc` are registered. The strobe is high for the one cycle after the clock edge that samples the decode. When the strobe is low, `exc_cause` is 0 and `exc_pc` is 0.
- R9: While `stall` is high, no exception is taken, the class state and the address-error latch hold their values, and `addr_err` and `dec_valid` are ignored.
- R10: Synchronous active-high `rst` clears the address-error latch, the previous-class state and all outputs.
- R11: A decode that takes an exception leaves no class behind, so the next instruction is neither a slot nor post-disable. A cycle with `dec_valid` low takes nothing and leaves the class state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes the unit and suppresses the strobe |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_is_dbranch | input | 1 | The decoded instruction is a delayed branch |
| dec_is_intdis | input | 1 | The decoded instruction is an interrupt-disabling register transfer |
| dec_undef | input | 1 | The decoded opcode is undefined |
| dec_pc | input | PC_W | Address of the decoded instruction |
| br_target | input | PC_W | Branch target, sampled together with a delayed branch |
| addr_err | input | 1 | Address-error event pulse |
| irq_level | input | LVL_W | Level of the requested interrupt |
| irq_mask | input | LVL_W | Current interrupt mask level |
| exc_take | output | 1 | One-cycle strobe: take an exception |
| exc_cause | output | 3 | 0 none, 1 general illegal, 2 illegal slot, 3 address error, 4 interrupt |
| exc_pc | output | PC_W | PC value to save |

## Verification
Every decision is made from the inputs presented before a rising edge and from state built up in earlier decodes. The result appears on the registered outputs right after that same edge, which is one cycle of latency with no further pipeline stages. The bench therefore applies one decode, waits for a single rising edge and compares all three outputs a fixed 1 ns later. Some vectors only seed state, such as a branch, a blocked pulse or a bubble. For those, the bench checks that the strobe stayed low, and the deferred effect is checked on the later vector where it must appear.

// File: rtl/exc_gate_pkg.sv
package exc_gate_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_ILLEGAL = 3'd1,
    CAUSE_ILLSLOT = 3'd2,
    CAUSE_ADDRERR = 3'd3,
    CAUSE_IRQ     = 3'd4
  } cause_e;
endpackage

// File: rtl/exc_class_trk.sv
module exc_class_trk #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            taken,
  input  logic            is_dbranch,
  input  logic            is_intdis,
  input  logic [PC_W-1:0] target_in,
  output logic            in_slot,
  output logic            after_dis,
  output logic [PC_W-1:0] slot_target
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot     <= 1'b0;
      after_dis   <= 1'b0;
      slot_target <= '0;
    end else if (adv) begin
      in_slot   <= is_dbranch & ~taken;
      after_dis <= is_intdis & ~taken;
      if (is_dbranch && !taken) slot_target <= target_in;
    end
  end
endmodule

// File: rtl/exc_pend.sv
module exc_pend (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic event_in,
  input  logic clr,
  output logic pend_any
);
  logic held;

  assign pend_any = held | event_in;

  always_ff @(posedge clk) begin
    if (rst)             held <= 1'b0;
    else if (en) begin
      if (clr)           held <= 1'b0;
      else if (event_in) held <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_sel.sv
module exc_sel
  import exc_gate_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            valid,
  input  logic            in_slot,
  input  logic            after_dis,
  input  logic            ae_any,
  input  logic            irq_ok,
  input  logic            undef,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] slot_target,
  output logic            take,
  output cause_e          cause,
  output logic [PC_W-1:0] save_pc,
  output logic            ae_taken
);
  logic ae_ok, ill_ok, int_ok;

  assign ae_ok  = valid & ae_any & ~in_slot;
  assign ill_ok = valid & undef;
  assign int_ok = valid & irq_ok & ~in_slot & ~after_dis;

  always_comb begin
    take     = 1'b1;
    cause    = CAUSE_NONE;
    save_pc  = pc;
    ae_taken = 1'b0;
    if (ae_ok) begin
      cause    = CAUSE_ADDRERR;
      ae_taken = 1'b1;
    end else if (ill_ok) begin
      if (in_slot) begin
        cause   = CAUSE_ILLSLOT;
        save_pc = slot_target;
      end else begin
        cause = CAUSE_ILLEGAL;
      end
    end else if (int_ok) begin
      cause = CAUSE_IRQ;
    end else begin
      take    = 1'b0;
      save_pc = '0;
    end
  end
endmodule

// File: rtl/exc_gate.sv
module exc_gate
  import exc_gate_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             dec_valid,
  input  logic             dec_is_dbranch,
  input  logic             dec_is_intdis,
  input  logic             dec_undef,
  input  logic [PC_W-1:0]  dec_pc,
  input  logic [PC_W-1:0]  br_target,
  input  logic             addr_err,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] irq_mask,
  output logic             exc_take,
  output logic [2:0]       exc_cause,
  output logic [PC_W-1:0]  exc_pc
);
  logic            adv;
  logic            slot_q, dis_q;
  logic [PC_W-1:0] tgt_q;
  logic            ae_any, ae_taken;
  logic            irq_ok;
  logic            take_now;
  cause_e          cause_now;
  logic [PC_W-1:0] pc_now;

  assign adv    = dec_valid & ~stall;
  assign irq_ok = irq_level > irq_mask;

  exc_class_trk #(.PC_W(PC_W)) u_trk (
    .clk(clk), .rst(rst), .adv(adv), .taken(take_now),
    .is_dbranch(dec_is_dbranch), .is_intdis(dec_is_intdis),
    .target_in(br_target), .in_slot(slot_q), .after_dis(dis_q),
    .slot_target(tgt_q)
  );

  exc_pend u_ae (
    .clk(clk), .rst(rst), .en(~stall), .event_in(addr_err),
    .clr(ae_taken), .pend_any(ae_any)
  );

  exc_sel #(.PC_W(PC_W)) u_sel (
    .valid(adv), .in_slot(slot_q), .after_dis(dis_q), .ae_any(ae_any),
    .irq_ok(irq_ok), .undef(dec_undef), .pc(dec_pc), .slot_target(tgt_q),
    .take(take_now), .cause(cause_now), .save_pc(pc_now), .ae_taken(ae_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_take  <= 1'b0;
      exc_cause <= CAUSE_NONE;
      exc_pc    <= '0;
    end else begin
      exc_take  <= take_now;
      exc_cause <= cause_now;
      exc_pc    <= pc_now;
    end
  end
endmodule

// File: rtl/exc_gate_chk.sv
module exc_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       dec_valid,
  input logic       dec_undef,
  input logic       in_slot,
  input logic       after_dis,
  input logic       exc_take,
  input logic [2:0] exc_cause
);
  p_slot_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !stall && in_slot) |=> !(exc_take && (exc_cause == 3'd3 || exc_cause == 3'd4)));

  p_dis_blocks_irq_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !stall && after_dis) |=> !(exc_take && exc_cause == 3'd4));

  p_undef_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !stall && dec_undef) |=> exc_take);

  p_idle_cause_r8: assert property (@(posedge clk) disable iff (rst)
    !exc_take |-> exc_cause == 3'd0);

  p_cause_range_r8: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> (exc_cause >= 3'd1 && exc_cause <= 3'd4));

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> !exc_take);
endmodule

bind exc_gate exc_gate_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .dec_valid(dec_valid),
  .dec_undef(dec_undef), .in_slot(slot_q), .after_dis(dis_q),
  .exc_take(exc_take), .exc_cause(exc_cause)
);

// File: tb/exc_gate_tb.sv
`timescale 1ns/1ps
module exc_gate_tb;
  localparam int PC_W = 32;
  localparam int LVL_W = 4;

  typedef struct packed {
    logic        v, db, ds, ud, ae;
    logic [3:0]  lv, mk;
    logic [15:0] pc, tg;
    logic        et;
    logic [2:0]  ec;
    logic [15:0] ep;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0, 0,0, 16'h0100,16'h0, 0,0,16'h0,    4'd8},  // R8 idle
    '{1,0,0,0,0, 5,3, 16'h0102,16'h0, 1,4,16'h0102, 4'd4},  // R4 level above mask
    '{1,0,0,0,0, 2,3, 16'h0104,16'h0, 0,0,16'h0,    4'd4},  // R4 below
    '{1,0,0,0,0, 3,3, 16'h0106,16'h0, 0,0,16'h0,    4'd4},  // R4 equal
    '{1,1,0,0,0, 0,3, 16'h0108,16'h0200, 0,0,16'h0, 4'd1},  // branch
    '{1,0,0,0,1, 5,3, 16'h010A,16'h0, 0,0,16'h0,    4'd1},  // R1 slot blocks both
    '{1,0,0,0,0, 5,3, 16'h0200,16'h0, 1,3,16'h0200, 4'd3},  // R3 held AE, R7 over irq
    '{1,0,0,0,0, 5,3, 16'h0202,16'h0, 1,4,16'h0202, 4'd7},  // R7 irq next
    '{1,0,1,0,0, 0,3, 16'h0204,16'h0, 0,0,16'h0,    4'd2},  // disabling instr
    '{1,0,0,0,0, 5,3, 16'h0206,16'h0, 0,0,16'h0,    4'd2},  // R2 irq blocked
    '{1,0,1,0,0, 0,3, 16'h0208,16'h0, 0,0,16'h0,    4'd2},
    '{1,0,0,0,1, 0,3, 16'h020A,16'h0, 1,3,16'h020A, 4'd2},  // R2 AE accepted
    '{1,0,0,1,0, 5,3, 16'h020C,16'h0, 1,1,16'h020C, 4'd5},  // R5, R7 illegal over irq
    '{1,0,0,0,0, 0,3, 16'h020E,16'h0, 0,0,16'h0,    4'd4},  // R4 withdrawn
    '{1,1,0,0,0, 0,3, 16'h0210,16'h0300, 0,0,16'h0, 4'd6},
    '{1,0,0,1,0, 0,3, 16'h0212,16'h0, 1,2,16'h0300, 4'd6},  // R6 slot illegal
    '{1,0,0,0,0, 0,3, 16'h0300,16'h0, 0,0,16'h0,    4'd6},
    '{1,1,0,0,0, 5,3, 16'h0302,16'h0400, 1,4,16'h0302, 4'd11}, // R11 branch taken by irq
    '{1,0,0,0,1, 0,3, 16'h0304,16'h0, 1,3,16'h0304, 4'd11}, // R11 not a slot
    '{0,0,0,0,0, 0,3, 16'h0306,16'h0, 0,0,16'h0,    4'd11}, // R11 bubble
    '{1,1,0,0,0, 0,3, 16'h0500,16'h0600, 0,0,16'h0, 4'd11},
    '{0,0,0,0,1, 0,3, 16'h0000,16'h0, 0,0,16'h0,    4'd11}, // bubble keeps class
    '{1,0,0,0,0, 0,3, 16'h0502,16'h0, 0,0,16'h0,    4'd3},  // R3 still blocked in slot
    '{1,0,0,0,0, 0,3, 16'h0600,16'h0, 1,3,16'h0600, 4'd3}   // R3 taken after slot
  };

  logic             clk = 1'b0;
  logic             rst, stall, dec_valid, dec_is_dbranch, dec_is_intdis, dec_undef, addr_err;
  logic [PC_W-1:0]  dec_pc, br_target, exc_pc;
  logic [LVL_W-1:0] irq_level, irq_mask;
  logic             exc_take;
  logic [2:0]       exc_cause;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_gate #(.PC_W(PC_W), .LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst(rst), .stall(stall), .dec_valid(dec_valid),
    .dec_is_dbranch(dec_is_dbranch), .dec_is_intdis(dec_is_intdis),
    .dec_undef(dec_undef), .dec_pc(dec_pc), .br_target(br_target),
    .addr_err(addr_err), .irq_level(irq_level), .irq_mask(irq_mask),
    .exc_take(exc_take), .exc_cause(exc_cause), .exc_pc(exc_pc)
  );

  task automatic drive(input logic v, db, ds, ud, ae, input logic [3:0] lv, mk,
                       input logic [15:0] pc, tg);
    dec_valid = v; dec_is_dbranch = db; dec_is_intdis = ds; dec_undef = ud;
    addr_err = ae; irq_level = lv; irq_mask = mk;
    dec_pc = {16'h0, pc}; br_target = {16'h0, tg};
  endtask

  task automatic idle();
    drive(0,0,0,0,0, 0,0, 16'h0, 16'h0);
  endtask

  task automatic check(input string req, input logic et, input logic [2:0] ec,
                       input logic [15:0] ep);
    checks++;
    if (exc_take !== et || exc_cause !== ec || exc_pc !== {16'h0, ep}) begin
      fails++;
      $display("FAIL %s: take=%0b cause=%0d pc=%h expected take=%0b cause=%0d pc=%h",
               req, exc_take, exc_cause, exc_pc, et, ec, {16'h0, ep});
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stall = 1'b0; idle();
    tick(); tick();
    check("R10", 0, 0, 16'h0);           // R10 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].db, VECS[i].ds, VECS[i].ud, VECS[i].ae,
            VECS[i].lv, VECS[i].mk, VECS[i].pc, VECS[i].tg);
      tick();
      check($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].et, VECS[i].ec, VECS[i].ep);
    end

    // R9: stall suppresses an undefined opcode
    stall = 1'b1; drive(1,0,0,1,0, 0,0, 16'h0700, 16'h0); tick();
    check("R9 stalled undef", 0, 0, 16'h0);
    // R9: address error pulse during stall is ignored
    drive(1,0,0,0,1, 0,0, 16'h0702, 16'h0); tick();
    check("R9 stalled ae", 0, 0, 16'h0);
    stall = 1'b0; drive(1,0,0,0,0, 0,0, 16'h0704, 16'h0); tick();
    check("R9 ae not latched", 0, 0, 16'h0);
    // R9: stall holds slot state
    drive(1,1,0,0,0, 0,0, 16'h0706, 16'h0800); tick();
    stall = 1'b1; drive(1,0,0,0,0, 9,0, 16'h0708, 16'h0); tick();
    check("R9 stall during slot", 0, 0, 16'h0);
    stall = 1'b0; drive(1,0,0,1,0, 9,0, 16'h0708, 16'h0); tick();
    check("R9 slot kept -> R6 target", 1, 2, 16'h0800);

    // R10: reset clears slot class and pending address error
    drive(1,1,0,0,0, 0,0, 16'h0900, 16'h0A00); tick();
    drive(1,0,0,0,1, 0,0, 16'h0902, 16'h0); tick();
    check("R1 slot blocks ae", 0, 0, 16'h0);
    rst = 1'b1; idle(); tick(); rst = 1'b0;
    check("R10 outputs cleared", 0, 0, 16'h0);
    drive(1,0,0,0,0, 0,0, 16'h0A00, 16'h0); tick();
    check("R10 pending ae cleared", 0, 0, 16'h0);
    drive(1,1,0,0,0, 0,0, 16'h0A02, 16'h0B00); tick();
    rst = 1'b1; idle(); tick(); rst = 1'b0;
    drive(1,0,0,0,0, 6,1, 16'h0A04, 16'h0); tick();
    check("R10 slot class cleared", 1, 4, 16'h0A04);
    // R8: strobe lasts one cycle
    idle(); tick();
    check("R8 single cycle", 0, 0, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule